// File: doc/BRIEF.md
# Static Memory Bus Cycle Sequencer

This block runs single read and write accesses to external ROM and SRAM devices. The 32-bit address space is split into fixed regions. A request comes in with address, direction, byte mask and write data on a valid/ready handshake. The block finds the region the address falls in and pulls that region's active-low chip select low for the whole external access. It places the read strobe, or the per-byte write strobes, according to the access length set for that region.

The block is clocked at twice the bus cycle rate. Every bus cycle therefore has a first and a second half-tick, and strobe edges can fall on half-cycle boundaries. The third region can add one address setup cycle ahead of the access. Each external region can add trailing hold cycles, and its hold-force bit decides whether they are inserted or skipped. A write that follows a read too closely gets one full idle bus cycle in front of it. Addresses in the internal-RAM window finish after one tick and drive nothing on the external bus. Read data is latched at the end of the last access cycle and returned with a one-tick completion pulse.

Top module: `sbc_static_bus`

## Requirements
- R1: The top three address bits select the region and its chip select: 000/001 drive `cs_n[0]`, 010/011 drive `cs_n[1]`, 100/101 drive `cs_n[2]`, 111 drives `cs_n[3]`, and 110 is the internal-RAM window.
- R2: For every external access, exactly one chip select is low. It is low in every tick of setup, access and hold, and high in every other tick. `bus_addr` equals the request address whenever a chip select is low.
- R3: A one-cycle access drives its strobe low only in the second half-tick of that bus cycle.
- R4: An access of N>1 bus cycles drives its strobe low from the first tick of the second bus cycle to the last tick of the Nth bus cycle, which is 2N-2 ticks.
- R5: On a write, `we_n[i]` is low during strobe ticks exactly when bit i of the byte mask is 1. `oe_n` stays high during writes and every `we_n` bit stays high during reads.
- R6: When `MEM2_SETUP` is 1, an access to the third region starts with one setup bus cycle (two ticks). During it the chip select is low and no strobe is low.
- R7: A region whose `HOLD_FORCE` bit is 1 adds its hold count of bus cycles after the access, keeping the chip select low, the address held and write data driven, with all strobes high. A region with its bit at 0 adds none.
- R8: A write accepted in the tick right after the last read-strobe tick starts with one idle bus cycle (two ticks, no chip select). A write accepted later, including after read hold cycles, starts with no idle cycle.
- R9: An access to the internal-RAM window drives no chip select and no strobe. It asserts `done` in the second tick after acceptance, with `rd_data` equal to zero.
- R10: `req_ready` is high only while idle. `done` is a one-tick pulse in the tick after the final tick of an access. `rd_data` holds `bus_din` as sampled at the end of the last access cycle.
- R11: After reset, every chip select and strobe is high, `req_ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus cycle rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_addr | input | 32 | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte mask for writes |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-tick completion pulse |
| rd_data | output | 32 | Read data, valid with `done` |
| bus_addr | output | 32 | External address |
| bus_dout | output | 32 | External write data |
| bus_dout_en | output | 1 | Write data driver enable |
| bus_din | input | 32 | External read data |
| cs_n | output | 4 | Active-low region chip selects |
| oe_n | output | 1 | Active-low read strobe |
| we_n | output | 4 | Active-low per-byte write strobes |

## Verification
The bench builds the block with access lengths 1, 3, 2 and 2 bus cycles for the four external regions. Hold cycles are forced only on the first two regions, and the third-region setup cycle is enabled. This puts the half-tick single-cycle strobe, the long multi-cycle strobe, the setup cycle, both forced and skipped hold, and a hold that alone covers the write turnaround gap all within one run. Back-to-back read-then-write pairs are issued at zero and one idle tick of separation to hit both sides of the turnaround rule.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BE_W   = DATA_W / 8;
    localparam int unsigned NUM_CS = 4;
    localparam int unsigned DEC_W  = 3;

    typedef enum logic [2:0] {
        RG_MEM0 = 3'd0,
        RG_MEM1 = 3'd1,
        RG_MEM2 = 3'd2,
        RG_MEM3 = 3'd3,
        RG_IRAM = 3'd4
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_ACC,
        ST_HOLD,
        ST_IRAM
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic region_e decode_region(input logic [DEC_W-1:0] top);
        case (top)
            3'b000, 3'b001: return RG_MEM0;
            3'b010, 3'b011: return RG_MEM1;
            3'b100, 3'b101: return RG_MEM2;
            3'b110:         return RG_IRAM;
            default:        return RG_MEM3;
        endcase
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sbc_region_dec.sv
module sbc_region_dec
    import sbc_pkg::*;
(
    input  logic [DEC_W-1:0] addr_top,
    output region_e          region
);
    always_comb region = decode_region(addr_top);
endmodule

// File: rtl/sbc_turnaround.sv
module sbc_turnaround #(
    parameter int unsigned GAP_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_end,
    output logic need_turn
);
    localparam int unsigned GW = (GAP_TICKS < 2) ? 1 : $clog2(GAP_TICKS);

    logic [GW-1:0] gap_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_left <= '0;
        end else if (rd_end) begin
            gap_left <= GW'(GAP_TICKS - 1);
        end else if (gap_left != '0) begin
            gap_left <= gap_left - 1'b1;
        end
    end

    assign need_turn = (gap_left != '0);

    assert_turn_flag_R8: assert property (@(posedge clk) disable iff (rst)
        rd_end |=> need_turn);
endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int unsigned ACC_MEM0   = 2,
    parameter int unsigned ACC_MEM1   = 2,
    parameter int unsigned ACC_MEM2   = 2,
    parameter int unsigned ACC_MEM3   = 2,
    parameter int unsigned HOLD_MEM0  = 1,
    parameter int unsigned HOLD_MEM1  = 1,
    parameter int unsigned HOLD_MEM2  = 1,
    parameter int unsigned HOLD_MEM3  = 1,
    parameter logic [3:0]  HOLD_FORCE = 4'b1111,
    parameter logic        MEM2_SETUP = 1'b1,
    parameter int unsigned CNT_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  req_t              req_in,
    input  region_e           region_in,
    input  logic              need_turn,
    input  logic [DATA_W-1:0] bus_din,
    output logic              req_ready,
    output state_e            state,
    output logic              ph,
    output logic [CNT_W-1:0]  cnt,
    output req_t              lat,
    output region_e           lreg,
    output logic              acc_single,
    output logic              rd_end,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    function automatic int unsigned acc_of(input region_e r);
        case (r)
            RG_MEM0: return ACC_MEM0;
            RG_MEM1: return ACC_MEM1;
            RG_MEM2: return ACC_MEM2;
            default: return ACC_MEM3;
        endcase
    endfunction

    function automatic int unsigned hold_of(input region_e r);
        case (r)
            RG_MEM0: return HOLD_MEM0;
            RG_MEM1: return HOLD_MEM1;
            RG_MEM2: return HOLD_MEM2;
            default: return HOLD_MEM3;
        endcase
    endfunction

    function automatic logic hold_forced(input region_e r);
        case (r)
            RG_MEM0: return HOLD_FORCE[0];
            RG_MEM1: return HOLD_FORCE[1];
            RG_MEM2: return HOLD_FORCE[2];
            default: return HOLD_FORCE[3];
        endcase
    endfunction

    function automatic logic wants_setup(input region_e r);
        return MEM2_SETUP && (r == RG_MEM2);
    endfunction

    logic acc_last, hold_last, hold_on;

    assign acc_last   = (cnt == CNT_W'(acc_of(lreg) - 1));
    assign hold_last  = (cnt == CNT_W'(hold_of(lreg) - 1));
    assign hold_on    = hold_forced(lreg) && (hold_of(lreg) != 0);
    assign acc_single = (acc_of(lreg) == 1);
    assign req_ready  = (state == ST_IDLE);
    assign rd_end     = (state == ST_ACC) && ph && acc_last && !lat.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ph      <= 1'b0;
            cnt     <= '0;
            lat     <= '0;
            lreg    <= RG_MEM0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat  <= req_in;
                        lreg <= region_in;
                        ph   <= 1'b0;
                        cnt  <= '0;
                        if (region_in == RG_IRAM)             state <= ST_IRAM;
                        else if (req_in.write && need_turn)   state <= ST_TURN;
                        else if (wants_setup(region_in))      state <= ST_SETUP;
                        else                                  state <= ST_ACC;
                    end
                end
                ST_IRAM: begin
                    state   <= ST_IDLE;
                    done    <= 1'b1;
                    rd_data <= '0;
                end
                ST_TURN: begin
                    ph <= ~ph;
                    if (ph) state <= wants_setup(lreg) ? ST_SETUP : ST_ACC;
                end
                ST_SETUP: begin
                    ph <= ~ph;
                    if (ph) state <= ST_ACC;
                end
                ST_ACC: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (acc_last) begin
                            cnt <= '0;
                            if (!lat.write) rd_data <= bus_din;
                            if (hold_on) begin
                                state <= ST_HOLD;
                            end else begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (hold_last) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/sbc_strobe.sv
module sbc_strobe
    import sbc_pkg::*;
#(
    parameter int unsigned CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  state_e            state,
    input  logic              ph,
    input  logic [CNT_W-1:0]  cnt,
    input  req_t              lat,
    input  region_e           lreg,
    input  logic              acc_single,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic [NUM_CS-1:0] cs_n,
    output logic              oe_n,
    output logic [BE_W-1:0]   we_n
);
    logic [NUM_CS-1:0] sel;
    logic              on_bus, strobe;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        assign sel[i] = (lreg == region_e'(3'(i)));
    end

    assign on_bus = (state == ST_SETUP) || (state == ST_ACC) || (state == ST_HOLD);
    assign strobe = (state == ST_ACC) && (acc_single ? ph : (cnt != '0));

    assign cs_n        = on_bus ? ~sel : '1;
    assign oe_n        = !(strobe && !lat.write);
    assign we_n        = (strobe && lat.write) ? ~lat.be : '1;
    assign bus_addr    = lat.addr;
    assign bus_dout    = lat.wdata;
    assign bus_dout_en = on_bus && lat.write;

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    assert_strobe_in_cs_R2: assert property (@(posedge clk) disable iff (rst)
        (!oe_n || (we_n != '1)) |-> (cs_n != '1));
    assert_oe_we_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && (we_n != '1)));
    assert_setup_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETUP) |-> (oe_n && (we_n == '1) && (cs_n != '1)));
endmodule

// File: rtl/sbc_static_bus.sv
module sbc_static_bus
    import sbc_pkg::*;
#(
    parameter int unsigned ACC_MEM0   = 2,
    parameter int unsigned ACC_MEM1   = 2,
    parameter int unsigned ACC_MEM2   = 2,
    parameter int unsigned ACC_MEM3   = 2,
    parameter int unsigned HOLD_MEM0  = 1,
    parameter int unsigned HOLD_MEM1  = 1,
    parameter int unsigned HOLD_MEM2  = 1,
    parameter int unsigned HOLD_MEM3  = 1,
    parameter logic [3:0]  HOLD_FORCE = 4'b1111,
    parameter logic        MEM2_SETUP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic [31:0]       rd_data,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_dout,
    output logic              bus_dout_en,
    input  logic [31:0]       bus_din,
    output logic [3:0]        cs_n,
    output logic              oe_n,
    output logic [3:0]        we_n
);
    localparam int unsigned MAX_CYC = max4(max4(ACC_MEM0, ACC_MEM1, ACC_MEM2, ACC_MEM3),
                                           HOLD_MEM0, max4(HOLD_MEM1, HOLD_MEM2, HOLD_MEM3, 1), 1);
    localparam int unsigned CNT_W   = bits_for(MAX_CYC);

    req_t             req_in, lat;
    region_e          region_in, lreg;
    state_e           state;
    logic             ph, acc_single, rd_end, need_turn;
    logic [CNT_W-1:0] cnt;

    assign req_in = '{addr: req_addr, write: req_write, be: req_be, wdata: req_wdata};

    sbc_region_dec u_dec (
        .addr_top (req_addr[ADDR_W-1 -: DEC_W]),
        .region   (region_in)
    );

    sbc_turnaround #(.GAP_TICKS(2)) u_turn (
        .clk       (clk),
        .rst       (rst),
        .rd_end    (rd_end),
        .need_turn (need_turn)
    );

    sbc_seq #(
        .ACC_MEM0 (ACC_MEM0), .ACC_MEM1 (ACC_MEM1), .ACC_MEM2 (ACC_MEM2), .ACC_MEM3 (ACC_MEM3),
        .HOLD_MEM0(HOLD_MEM0), .HOLD_MEM1(HOLD_MEM1), .HOLD_MEM2(HOLD_MEM2), .HOLD_MEM3(HOLD_MEM3),
        .HOLD_FORCE(HOLD_FORCE), .MEM2_SETUP(MEM2_SETUP), .CNT_W(CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_in     (req_in),
        .region_in  (region_in),
        .need_turn  (need_turn),
        .bus_din    (bus_din),
        .req_ready  (req_ready),
        .state      (state),
        .ph         (ph),
        .cnt        (cnt),
        .lat        (lat),
        .lreg       (lreg),
        .acc_single (acc_single),
        .rd_end     (rd_end),
        .done       (done),
        .rd_data    (rd_data)
    );

    sbc_strobe #(.CNT_W(CNT_W)) u_stb (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .ph          (ph),
        .cnt         (cnt),
        .lat         (lat),
        .lreg        (lreg),
        .acc_single  (acc_single),
        .bus_addr    (bus_addr),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en),
        .cs_n        (cs_n),
        .oe_n        (oe_n),
        .we_n        (we_n)
    );

    assert_iram_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IRAM) |-> ((cs_n == '1) && oe_n && (we_n == '1)));
    assert_turn_gap_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |=> (we_n == '1));
endmodule

// File: tb/sbc_static_bus_bench.sv
module sbc_static_bus_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rd_data, bus_addr, bus_dout;
    logic        bus_dout_en;
    logic [31:0] bus_din = '0;
    logic [3:0]  cs_n, we_n;
    logic        oe_n;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    sbc_static_bus #(
        .ACC_MEM0(1), .ACC_MEM1(3), .ACC_MEM2(2), .ACC_MEM3(2),
        .HOLD_MEM0(1), .HOLD_MEM1(2), .HOLD_MEM2(1), .HOLD_MEM3(3),
        .HOLD_FORCE(4'b0011), .MEM2_SETUP(1'b1)
    ) u_sbc_static_bus (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .bus_din(bus_din), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n)
    );

    // expected timing model, in ticks (two per bus cycle)
    function automatic int acc_p(input int r);
        case (r) 0: return 1; 1: return 3; 2: return 2; default: return 2; endcase
    endfunction
    function automatic int hold_t(input int r);
        case (r) 0: return 2; 1: return 4; default: return 0; endcase
    endfunction
    function automatic int setup_t(input int r);
        return (r == 2) ? 2 : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // measurements of the last access
    int m_first_cs, m_cs_cnt, m_oe_first, m_oe_cnt, m_we_first, m_we_cnt, m_done_idx;
    int m_addr_bad, m_data_bad, m_ready_bad;
    logic [3:0]  m_cs_val, m_we_val;
    logic [31:0] m_rd;

    // Called at a negedge; returns at the negedge where done is seen.
    task automatic run_acc(input logic [31:0] a, input bit wr, input logic [3:0] be,
                           input logic [31:0] wd, input logic [31:0] din);
        int k;
        req_addr = a; req_write = wr; req_be = be; req_wdata = wd; bus_din = din;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        m_first_cs = -1; m_cs_cnt = 0; m_oe_first = -1; m_oe_cnt = 0;
        m_we_first = -1; m_we_cnt = 0; m_done_idx = -1; m_addr_bad = 0;
        m_data_bad = 0; m_ready_bad = 0; m_cs_val = 4'hF; m_we_val = 4'hF;
        k = 0;
        while (k < 100) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done) begin
                m_done_idx = k;
                m_rd = rd_data;
                break;
            end
            if (req_ready) m_ready_bad++;
            if (cs_n != 4'hF) begin
                if (m_first_cs < 0) m_first_cs = k;
                m_cs_cnt++;
                m_cs_val = cs_n;
                if (bus_addr != a) m_addr_bad++;
                if (wr && (!bus_dout_en || bus_dout != wd)) m_data_bad++;
            end
            if (!oe_n) begin
                if (m_oe_first < 0) m_oe_first = k;
                m_oe_cnt++;
            end else if (m_oe_cnt > 0) begin
                bus_din = ~din;
            end
            if (we_n != 4'hF) begin
                if (m_we_first < 0) m_we_first = k;
                m_we_cnt++;
                m_we_val = we_n;
            end
            k++;
        end
    endtask

    // check one external access against the model
    task automatic check_ext(input string tag, input int r, input bit wr, input int turn,
                             input logic [3:0] be, input logic [31:0] din);
        int a_t, exp_first, exp_cnt;
        a_t = acc_p(r);
        exp_first = turn + setup_t(r) + ((a_t == 1) ? 1 : 2);
        exp_cnt   = (a_t == 1) ? 1 : 2 * a_t - 2;
        chk(m_cs_val == ~(4'b0001 << r), {tag, " R1 cs select"}, int'(m_cs_val), int'(~(4'b0001 << r)) & 15);
        chk(m_first_cs == turn, {tag, " R8 cs start"}, m_first_cs, turn);
        chk(m_cs_cnt == setup_t(r) + 2 * a_t + hold_t(r), {tag, " R2/R7 cs ticks"},
            m_cs_cnt, setup_t(r) + 2 * a_t + hold_t(r));
        chk(m_addr_bad == 0, {tag, " R2 address held"}, m_addr_bad, 0);
        chk(m_done_idx == turn + setup_t(r) + 2 * a_t + hold_t(r), {tag, " R10 done tick"},
            m_done_idx, turn + setup_t(r) + 2 * a_t + hold_t(r));
        chk(m_ready_bad == 0, {tag, " R10 ready while busy"}, m_ready_bad, 0);
        if (wr) begin
            chk(m_we_first == exp_first, {tag, (a_t == 1) ? " R3 we start" : " R4 we start"}, m_we_first, exp_first);
            chk(m_we_cnt == exp_cnt, {tag, (a_t == 1) ? " R3 we ticks" : " R4 we ticks"}, m_we_cnt, exp_cnt);
            chk(m_we_val == ~be, {tag, " R5 byte strobes"}, int'(m_we_val), int'(~be) & 15);
            chk(m_oe_cnt == 0, {tag, " R5 no oe on write"}, m_oe_cnt, 0);
            chk(m_data_bad == 0, {tag, " R7 write data held"}, m_data_bad, 0);
        end else begin
            chk(m_oe_first == exp_first, {tag, (a_t == 1) ? " R3 oe start" : " R4 oe start"}, m_oe_first, exp_first);
            chk(m_oe_cnt == exp_cnt, {tag, (a_t == 1) ? " R3 oe ticks" : " R4 oe ticks"}, m_oe_cnt, exp_cnt);
            chk(m_we_cnt == 0, {tag, " R5 no we on read"}, m_we_cnt, 0);
            chk(m_rd == din, {tag, " R10 read data"}, int'(m_rd), int'(din));
        end
    endtask

    task automatic t_reset;
        chk(cs_n == 4'hF, "R11 cs after reset", int'(cs_n), 15);
        chk(oe_n == 1'b1 && we_n == 4'hF, "R11 strobes after reset", int'({oe_n, we_n}), 31);
        chk(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
        chk(done == 1'b0, "R11 done after reset", int'(done), 0);
    endtask

    task automatic t_iram;
        run_acc(32'hC000_0000, 1'b0, 4'h0, 32'h0, 32'h1234_5678);
        chk(m_cs_cnt == 0 && m_oe_cnt == 0 && m_we_cnt == 0, "R9 iram read quiet", m_cs_cnt + m_oe_cnt, 0);
        chk(m_done_idx == 1, "R9 iram done tick", m_done_idx, 1);
        chk(m_rd == 32'h0, "R9 iram read data", int'(m_rd), 0);
        @(negedge clk);
        run_acc(32'hDFFF_FFFC, 1'b1, 4'hF, 32'hAAAA_5555, 32'h0);
        chk(m_cs_cnt == 0 && m_we_cnt == 0, "R9 iram write quiet", m_cs_cnt + m_we_cnt, 0);
        chk(m_done_idx == 1, "R1 R9 iram top edge", m_done_idx, 1);
    endtask

    task automatic t_decode_edges;
        @(negedge clk);
        run_acc(32'h3FFF_FFFC, 1'b0, 4'h0, 32'h0, 32'h0101_0101);
        check_ext("MEM0 top R1", 0, 1'b0, 0, 4'h0, 32'h0101_0101);
        @(negedge clk);
        run_acc(32'h4000_0000, 1'b0, 4'h0, 32'h0, 32'h0202_0202);
        check_ext("MEM1 base R1", 1, 1'b0, 0, 4'h0, 32'h0202_0202);
        @(negedge clk);
        run_acc(32'hBFFF_FFF0, 1'b0, 4'h0, 32'h0, 32'h0303_0303);
        check_ext("MEM2 top R6", 2, 1'b0, 0, 4'h0, 32'h0303_0303);
        chk(m_oe_first == 4, "R6 strobe after setup", m_oe_first, 4);
        @(negedge clk);
        run_acc(32'hE000_0000, 1'b0, 4'h0, 32'h0, 32'h0404_0404);
        check_ext("MEM3 base R7 skip", 3, 1'b0, 0, 4'h0, 32'h0404_0404);
    endtask

    task automatic t_writes;
        @(negedge clk);
        @(negedge clk);
        run_acc(32'h0000_0100, 1'b1, 4'b0101, 32'hDEAD_BEEF, 32'h0);
        check_ext("MEM0 single write R3", 0, 1'b1, 0, 4'b0101, 32'h0);
        @(negedge clk);
        run_acc(32'h4000_0200, 1'b1, 4'b1000, 32'hCAFE_F00D, 32'h0);
        check_ext("MEM1 long write R4", 1, 1'b1, 0, 4'b1000, 32'h0);
        @(negedge clk);
        run_acc(32'h8000_0040, 1'b1, 4'b0110, 32'h1357_9BDF, 32'h0);
        check_ext("MEM2 setup write R6", 2, 1'b1, 0, 4'b0110, 32'h0);
    endtask

    task automatic t_turnaround;
        @(negedge clk);
        run_acc(32'hF000_0000, 1'b0, 4'h0, 32'h0, 32'h5A5A_A5A5);
        check_ext("MEM3 read R10", 3, 1'b0, 0, 4'h0, 32'h5A5A_A5A5);
        run_acc(32'hF000_0004, 1'b1, 4'hF, 32'h0F0F_F0F0, 32'h0);
        check_ext("write right after read R8", 3, 1'b1, 2, 4'hF, 32'h0);
        @(negedge clk);
        run_acc(32'hF000_0008, 1'b0, 4'h0, 32'h0, 32'h7777_8888);
        @(negedge clk);
        run_acc(32'hF000_000C, 1'b1, 4'b0011, 32'h2468_ACE0, 32'h0);
        check_ext("write one idle tick later R8", 3, 1'b1, 0, 4'b0011, 32'h0);
        @(negedge clk);
        run_acc(32'h4000_0010, 1'b0, 4'h0, 32'h0, 32'h9999_0000);
        run_acc(32'h0000_0020, 1'b1, 4'b1111, 32'h1111_2222, 32'h0);
        check_ext("write after forced hold R8 R7", 0, 1'b1, 0, 4'b1111, 32'h0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one tick", int'(done), 0);
        chk(cs_n == 4'hF && oe_n && we_n == 4'hF, "R2 bus released when idle", int'(cs_n), 15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_iram();
        t_decode_edges();
        t_writes();
        t_turnaround();
        repeat (4) @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule